// File: doc/BRIEF.md
# Successive-Approximation Oscillator Code Search Controller

This controller brings a digitally controlled oscillator close to its target frequency before a proportional-integral tracking loop takes over. It runs on the reference clock. A start request launches a fixed sequence of twelve reference periods. The first two periods form a delay-alignment step. That step decides whether a delayed copy of the reference should feed the phase detector. The remaining ten periods form a binary search over the oscillator control code, and each period resolves one bit.

The only feedback is the one-bit UP output of a bang-bang phase detector. The detector compares the chosen reference edge with the divided oscillator output, so no frequency counter is needed. UP high means the oscillator is too slow. Each trial bit is first set to 1. It stays 1 if UP is seen high one period later, and otherwise it is cleared. When the least significant bit resolves, a one-cycle done pulse marks the final code. That code then stays fixed until the next start, so the tracking loop can load it. After completion, a configuration input decides whether the found delay choice is applied or the raw reference is used.

Top module: `sar_code_search`

## Requirements
- R1: After reset, `code_o` is mid-scale 10'b1000000000, `dly_sel_o` is 0 and `done_o` is 0.
- R2: A `start_i` sampled high while idle begins the delay-alignment step. In the first period after that edge, `dly_sel_o` is 0 (raw reference) and `code_o` is mid-scale. In the second period, `dly_sel_o` is 1 (delayed reference).
- R3: At the end of the second alignment period, the found delay choice becomes the UP sampled in the raw period XOR the UP sampled in the delayed period. During the frequency search, `dly_sel_o` equals this choice.
- R4: The frequency search takes exactly 10 periods and starts with code 10'b1000000000. At each edge the trial bit k takes the value of the sampled `up_i`, bit k-1 (when k>0) is set to 1, and the lower bits are 0. Bits are resolved from bit 9 down to bit 0.
- R5: `done_o` is high for exactly one period. That period is the twelfth after the start edge, and `code_o` then holds the complete result.
- R6: While idle with no start, `code_o` stays stable whatever `up_i` does.
- R7: `start_i` has no effect while a search is running.
- R8: Once a search has completed, `dly_sel_o` equals `use_dly_i` AND the found delay choice, sampled one edge earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin a new search |
| up_i | input | 1 | Bang-bang detector decision, 1 = oscillator slow |
| use_dly_i | input | 1 | Apply the found delay choice after completion |
| code_o | output | 10 | Oscillator control code |
| dly_sel_o | output | 1 | 1 = delayed reference drives the detector |
| done_o | output | 1 | One-cycle pulse when the last bit resolves |

## Verification
Searches are run with UP held high throughout and held low throughout. These give the all-ones and all-zeros codes and catch a swapped keep/clear rule. An alternating UP pattern exposes bit-ordering and index mistakes. Random UP sequences, with random alignment decisions and random start pulses injected mid-search, separate a correct XOR delay choice and an ignored restart from a controller that re-launches or misreads the alignment samples. Toggling the configuration input while idle shows whether the delay select follows the found choice only after completion.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ALIGN = 2'd1,
    PH_SEARCH = 2'd2
  } phase_e;
endpackage

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int CODE_W = 10,
  localparam int IW = $clog2(CODE_W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  output phase_e        phase_o,
  output logic          slot_o,
  output logic [IW-1:0] bit_o,
  output logic          done_o
);
  // slot_o: 0 = raw-reference period, 1 = delayed-reference period
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_o <= PH_IDLE;
      slot_o  <= 1'b0;
      bit_o   <= IW'(CODE_W - 1);
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (phase_o)
        PH_IDLE: begin
          if (start_i) begin
            phase_o <= PH_ALIGN;
            slot_o  <= 1'b0;
          end
        end
        PH_ALIGN: begin
          if (slot_o) begin
            phase_o <= PH_SEARCH;
            bit_o   <= IW'(CODE_W - 1);
            slot_o  <= 1'b0;
          end else begin
            slot_o <= 1'b1;
          end
        end
        PH_SEARCH: begin
          if (bit_o == '0) begin
            phase_o <= PH_IDLE;
            done_o  <= 1'b1;
          end else begin
            bit_o <= bit_o - IW'(1);
          end
        end
        default: phase_o <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_code_reg.sv
module sar_code_reg #(
  parameter int CODE_W = 10,
  localparam int IW = $clog2(CODE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_mid_i,
  input  logic              step_i,
  input  logic [IW-1:0]     bit_i,
  input  logic              up_i,
  output logic [CODE_W-1:0] code_o
);
  for (genvar i = 0; i < CODE_W; i++) begin : g_bit
    localparam logic MID_V = (i == CODE_W - 1);
    logic nxt_trial;
    if (i == CODE_W - 1) begin : g_top
      assign nxt_trial = 1'b0;
    end else begin : g_low
      assign nxt_trial = (bit_i == IW'(i + 1));
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        code_o[i] <= MID_V;
      end else if (load_mid_i) begin
        code_o[i] <= MID_V;
      end else if (step_i && bit_i == IW'(i)) begin
        code_o[i] <= up_i;
      end else if (step_i && nxt_trial) begin
        code_o[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sar_dly_pick.sv
module sar_dly_pick (
  input  logic clk,
  input  logic rst,
  input  logic begin_i,
  input  logic raw_end_i,
  input  logic dly_end_i,
  input  logic last_i,
  input  logic idle_i,
  input  logic up_i,
  input  logic use_dly_i,
  output logic sel_o
);
  logic up_raw_q;
  logic found_q;
  logic valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      up_raw_q <= 1'b0;
      found_q  <= 1'b0;
      valid_q  <= 1'b0;
      sel_o    <= 1'b0;
    end else if (begin_i) begin
      valid_q <= 1'b0;
      sel_o   <= 1'b0;
    end else if (raw_end_i) begin
      up_raw_q <= up_i;
      sel_o    <= 1'b1;
    end else if (dly_end_i) begin
      found_q <= up_raw_q ^ up_i;
      sel_o   <= up_raw_q ^ up_i;
    end else if (last_i) begin
      valid_q <= 1'b1;
      sel_o   <= use_dly_i & found_q;
    end else if (idle_i) begin
      sel_o <= valid_q & use_dly_i & found_q;
    end
  end
endmodule

// File: rtl/sar_code_search.sv
module sar_code_search
  import sar_pkg::*;
#(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              up_i,
  input  logic              use_dly_i,
  output logic [CODE_W-1:0] code_o,
  output logic              dly_sel_o,
  output logic              done_o
);
  localparam int IW = $clog2(CODE_W);

  phase_e        phase_q;
  logic          slot_q;
  logic [IW-1:0] bit_q;
  logic          accept;
  logic          raw_end;
  logic          dly_end;
  logic          step;
  logic          last;
  logic          idle_hold;

  sar_seq #(.CODE_W(CODE_W)) u_seq (
    .clk(clk), .rst(rst), .start_i(start_i),
    .phase_o(phase_q), .slot_o(slot_q), .bit_o(bit_q), .done_o(done_o)
  );

  assign accept    = (phase_q == PH_IDLE) && start_i;
  assign idle_hold = (phase_q == PH_IDLE) && !start_i;
  assign raw_end   = (phase_q == PH_ALIGN) && !slot_q;
  assign dly_end   = (phase_q == PH_ALIGN) && slot_q;
  assign step      = (phase_q == PH_SEARCH);
  assign last      = step && (bit_q == '0);

  sar_code_reg #(.CODE_W(CODE_W)) u_code (
    .clk(clk), .rst(rst), .load_mid_i(accept | dly_end), .step_i(step),
    .bit_i(bit_q), .up_i(up_i), .code_o(code_o)
  );

  sar_dly_pick u_dly (
    .clk(clk), .rst(rst), .begin_i(accept), .raw_end_i(raw_end),
    .dly_end_i(dly_end), .last_i(last), .idle_i(idle_hold),
    .up_i(up_i), .use_dly_i(use_dly_i), .sel_o(dly_sel_o)
  );
endmodule

// File: rtl/sar_code_search_chk.sv
module sar_code_search_chk
  import sar_pkg::*;
#(
  parameter int CODE_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input phase_e            phase_q,
  input logic [CODE_W-1:0] code_o,
  input logic              dly_sel_o,
  input logic              done_o
);
  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (code_o == MID && !dly_sel_o && !done_o));

  a_r2_align_raw_first: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IDLE && start_i) |=> (!dly_sel_o && code_o == MID));

  a_r4_single_step: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_SEARCH) |=> ($countones(code_o ^ $past(code_o)) <= 2));

  a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IDLE && !start_i) |=> $stable(code_o));

  a_r7_no_restart: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_SEARCH && start_i) |=> (phase_q != PH_ALIGN));
endmodule

bind sar_code_search sar_code_search_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .phase_q(phase_q),
  .code_o(code_o), .dly_sel_o(dly_sel_o), .done_o(done_o)
);

// File: tb/sar_code_search_test.sv
module sar_code_search_test;
  localparam int W = 10;
  localparam logic [W-1:0] MID = 10'b1000000000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic up_i = 1'b0;
  logic use_dly_i = 1'b0;
  logic [W-1:0] code_o;
  logic dly_sel_o;
  logic done_o;
  int checks = 0;
  int errors = 0;
  int seed_v;

  always #2.5 clk = ~clk;

  sar_code_search #(.CODE_W(W)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .up_i(up_i),
    .use_dly_i(use_dly_i), .code_o(code_o), .dly_sel_o(dly_sel_o),
    .done_o(done_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] partial(input logic [W-1:0] ups, input int b);
    logic [W-1:0] r = '0;
    for (int i = W - 1; i >= b; i--) r[i] = ups[i];
    if (b > 0) r[b-1] = 1'b1;
    return r;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run(input logic ur, input logic ud, input logic [W-1:0] ups,
                     input logic use_d, input logic noisy);
    logic found;
    found = ur ^ ud;
    use_dly_i = use_d;
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    chk("R2 raw select", dly_sel_o, 0);
    chk("R2 mid code", code_o, MID);
    up_i = ur;
    tick();
    chk("R2 delayed select", dly_sel_o, 1);
    up_i = ud;
    if (noisy) start_i = 1'($urandom);
    tick();
    chk("R3 found choice", dly_sel_o, found);
    chk("R4 first trial", code_o, MID);
    for (int b = W - 1; b >= 0; b--) begin
      up_i = ups[b];
      if (noisy) start_i = 1'($urandom);   // R7 stimulus
      tick();
      chk("R4 R7 partial code", code_o, partial(ups, b));
      if (b > 0) chk("R5 no early done", done_o, 0);
      else begin
        chk("R5 done pulse", done_o, 1);
        chk("R8 select at done", dly_sel_o, use_d & found);
      end
    end
    start_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      up_i = 1'($urandom);
      use_dly_i = 1'($urandom);
      tick();
      chk("R5 done cleared", done_o, 0);
      chk("R6 code held", code_o, ups);
      chk("R8 select follows cfg", dly_sel_o, use_dly_i & found);
    end
  endtask

  initial begin
    seed_v = $urandom(32'h5A3C);
    repeat (3) tick();
    rst = 1'b0;
    chk("R1 code", code_o, MID);
    chk("R1 select", dly_sel_o, 0);
    chk("R1 done", done_o, 0);
    up_i = 1'b1;
    tick();
    chk("R6 idle before start", code_o, MID);
    run(1'b0, 1'b0, 10'h3FF, 1'b1, 1'b0);
    run(1'b0, 1'b1, 10'h000, 1'b1, 1'b0);
    run(1'b1, 1'b0, 10'h2AA, 1'b0, 1'b1);
    run(1'b1, 1'b1, 10'h155, 1'b1, 1'b1);
    for (int n = 0; n < 30; n++)
      run(1'($urandom), 1'($urandom), W'($urandom), 1'($urandom), 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule